// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between an 8-bit console CPU bus and the storage on a game cartridge. CPU writes into the lower half of the address space (0x0000–0x7FFF) do not reach storage. They are decoded as control writes. These writes pick the switchable ROM bank and the external RAM bank, and turn the external RAM on or off. For every bus address, the block produces the physical ROM address and the physical RAM address. It also produces a flag that says whether the cartridge drives read data; when the flag is low the CPU sees open bus (0xFF). A write strobe is produced for the external RAM.

A parameter chooses between two register layouts. The narrow layout has a 5-bit low ROM bank field and a 2-bit shared field; a mode bit decides whether the shared field extends the ROM bank or selects the RAM bank. The wide layout has a 9-bit ROM bank, in which bank 0 can be selected, and a full-byte RAM bank. When a real-time clock is fitted, RAM bank numbers 8 to 12 redirect the RAM window to one of five clock registers. The clock's storage and timekeeping live outside this block.

Bank numbers wrap around the memory size whenever that size is a power of two, so software that counts past the end of memory lands back on a valid bank.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0, external RAM is disabled and the mode bit is 0.
- R2: A write anywhere in 0x0000–0x1FFF enables external RAM when the data is exactly 0x0A, and disables it for any other data.
- R3: A write to 0x2000–0x2FFF loads the low ROM bank field. In the narrow variant the field is data bits 4:0, a zero value is written as 1, and bank bits 8:5 are kept. In the wide variant the field is data bits 7:0, zero is kept, and bank bit 8 is kept.
- R4: In the wide variant, a write to 0x3000–0x3FFF sets ROM bank bit 8 from data bit 0 and keeps bits 7:0. In the narrow variant this range acts exactly like 0x2000–0x2FFF.
- R5: A write to 0x4000–0x5FFF in the narrow variant puts data bits 1:0 into the RAM bank when the mode bit is 1, and into ROM bank bits 6:5 when the mode bit is 0. In the wide variant the whole data byte becomes the RAM bank.
- R6: In the narrow variant, a write to 0x6000–0x7FFF sets the mode bit from data bit 0. Going from 0 to 1 moves ROM bank bits 6:5 into the RAM bank and clears them in the ROM bank. Going from 1 to 0 moves RAM bank bits 1:0 back into ROM bank bits 6:5 and sets the RAM bank to 0. In the wide variant this range has no effect.
- R7: After each control write, when ROM_BANKS is a power of two, the ROM bank is reduced modulo ROM_BANKS. Otherwise it is left as written.
- R8: After each control write, when RAM_BANKS is a power of two, the RAM bank is reduced modulo RAM_BANKS. The exception is a clock-fitted block, where the values 8–12 are kept unchanged.
- R9: In the narrow variant the ROM bank is never 0. A zero left after the wrap of R7 is replaced by 1.
- R10: For addresses 0x4000–0x7FFF, rom_addr is {ROM bank, addr[13:0]}. rd_valid is 1 only when the ROM bank is below ROM_BANKS.
- R11: ram_addr is always {RAM bank, addr[12:0]}. For addresses 0xA000–0xBFFF that are not redirected to the clock, rd_valid and ram_we (with wr_en) require RAM to be enabled and the RAM bank to be below RAM_BANKS.
- R12: With the clock fitted, an access to 0xA000–0xBFFF while the RAM bank is 8+k (k = 0..4) sets only clk_sel[k]. rd_valid is then 1 and clk_we follows wr_en, whether or not RAM is enabled. ram_we stays 0, and clk_fill reads 0x3E (bits that read as 1) only for k = 4.
- R13: For addresses 0x0000–0x3FFF, rom_addr is {9'b0, addr[13:0]} and rd_valid is 1. For 0x8000–0x9FFF and 0xC000–0xFFFF, rd_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe for the current address |
| addr | input | 16 | CPU bus address |
| wdata | input | 8 | CPU write data |
| rom_addr | output | 23 | Physical ROM byte address |
| ram_addr | output | 21 | Physical RAM byte address |
| rd_valid | output | 1 | Cartridge drives read data; low means open bus |
| ram_we | output | 1 | Write strobe to external RAM |
| clk_sel | output | 5 | One-hot clock register select |
| clk_we | output | 1 | Write strobe to the selected clock register |
| clk_fill | output | 8 | Mask of clock register bits that read as 1 |

## Verification
The properties assume that wr_en, addr and wdata always carry known values, and that reset is held at start-up before the first control write. They also assume a control write takes effect on the bank registers in the cycle after it is presented. The bench meets these assumptions: it holds reset for several cycles, drives every input with defined values half a cycle away from the sampling edge, and keeps wr_en low whenever it only wants to observe the address mapping. The random addresses are weighted toward the control ranges and the two windows. The random data is weighted toward 0x0A and the clock bank numbers, so that enable toggles and clock redirection happen often.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
   // register layout variants
   typedef enum logic {
      VAR_MODE5 = 1'b0,   // 5-bit low field, 2-bit shared field, mode bit
      VAR_WIDE9 = 1'b1    // 9-bit ROM bank, byte-wide RAM bank
   } variant_e;

   localparam int BANK_ROM_W = 9;
   localparam int BANK_RAM_W = 8;
   localparam int ROM_OFS_W  = 14;
   localparam int RAM_OFS_W  = 13;
   localparam int ROM_PAW    = BANK_ROM_W + ROM_OFS_W;
   localparam int RAM_PAW    = BANK_RAM_W + RAM_OFS_W;
   localparam int CLK_REGS   = 5;
   localparam int CLK_BASE   = 8;
   localparam logic [7:0] RAM_KEY       = 8'h0A;
   localparam logic [7:0] CLK_LAST_FILL = 8'h3E;

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/cbc_bank_regs.sv
module cbc_bank_regs
   import cbc_pkg::*;
#(
   parameter variant_e VARIANT   = VAR_MODE5,
   parameter int       ROM_BANKS = 64,
   parameter int       RAM_BANKS = 4,
   parameter bit       HAS_CLOCK = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [15:0]           addr,
   input  logic [7:0]            wdata,
   output logic [BANK_ROM_W-1:0] rom_bank,
   output logic [BANK_RAM_W-1:0] ram_bank,
   output logic                  ram_en,
   output logic                  bank_mode
);
   localparam bit ROM_POW2 = is_pow2(ROM_BANKS);
   localparam bit RAM_POW2 = is_pow2(RAM_BANKS);
   localparam logic [BANK_ROM_W-1:0] ROM_MASK = BANK_ROM_W'(ROM_BANKS - 1);
   localparam logic [BANK_RAM_W-1:0] RAM_MASK = BANK_RAM_W'(RAM_BANKS - 1);
   localparam logic [BANK_RAM_W-1:0] CLK_LO   = BANK_RAM_W'(CLK_BASE);
   localparam logic [BANK_RAM_W-1:0] CLK_HI   = BANK_RAM_W'(CLK_BASE + CLK_REGS - 1);

   logic                  ctl_wr;
   logic [2:0]            region;
   logic                  raw_en;
   logic                  raw_mode;
   logic [BANK_ROM_W-1:0] raw_rom;
   logic [BANK_RAM_W-1:0] raw_ram;
   logic [BANK_ROM_W-1:0] nrm_rom;
   logic [BANK_RAM_W-1:0] nrm_ram;
   logic                  clk_keep;

   assign ctl_wr = wr_en & ~addr[15];
   assign region = addr[14:12];

   always_comb begin
      raw_en = ram_en;
      if (ctl_wr && region[2:1] == 2'b00) raw_en = (wdata == RAM_KEY);
   end

   generate
      if (VARIANT == VAR_MODE5) begin : g_mode5
         logic [4:0] low5;
         assign low5 = (wdata[4:0] == 5'd0) ? 5'd1 : wdata[4:0];
         always_comb begin
            raw_rom  = rom_bank;
            raw_ram  = ram_bank;
            raw_mode = bank_mode;
            if (ctl_wr) begin
               case (region)
                  3'd2, 3'd3: raw_rom[4:0] = low5;
                  3'd4, 3'd5: begin
                     if (bank_mode) raw_ram = {6'd0, wdata[1:0]};
                     else           raw_rom[6:5] = wdata[1:0];
                  end
                  3'd6, 3'd7: begin
                     raw_mode = wdata[0];
                     if (wdata[0] && !bank_mode) begin
                        raw_ram      = {6'd0, rom_bank[6:5]};
                        raw_rom[6:5] = 2'b00;
                     end else if (!wdata[0] && bank_mode) begin
                        raw_rom[6:5] = ram_bank[1:0];
                        raw_ram      = '0;
                     end
                  end
                  default: ;
               endcase
            end
         end
      end else begin : g_wide9
         always_comb begin
            raw_rom  = rom_bank;
            raw_ram  = ram_bank;
            raw_mode = 1'b0;
            if (ctl_wr) begin
               case (region)
                  3'd2:       raw_rom[7:0] = wdata;
                  3'd3:       raw_rom[8]   = wdata[0];
                  3'd4, 3'd5: raw_ram      = wdata;
                  default: ;
               endcase
            end
         end
      end
   endgenerate

   // wrap, then the narrow layout's bank-zero substitution
   always_comb begin
      nrm_rom = ROM_POW2 ? (raw_rom & ROM_MASK) : raw_rom;
      if (VARIANT == VAR_MODE5 && nrm_rom == '0) nrm_rom = BANK_ROM_W'(1);
      clk_keep = HAS_CLOCK && (raw_ram >= CLK_LO) && (raw_ram <= CLK_HI);
      nrm_ram  = (RAM_POW2 && !clk_keep) ? (raw_ram & RAM_MASK) : raw_ram;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rom_bank  <= BANK_ROM_W'(1);
         ram_bank  <= '0;
         ram_en    <= 1'b0;
         bank_mode <= 1'b0;
      end else if (ctl_wr) begin
         rom_bank  <= nrm_rom;
         ram_bank  <= nrm_ram;
         ram_en    <= raw_en;
         bank_mode <= raw_mode;
      end
   end
endmodule

// File: rtl/cbc_addr_map.sv
module cbc_addr_map
   import cbc_pkg::*;
#(
   parameter int ROM_BANKS = 64,
   parameter int RAM_BANKS = 4,
   parameter bit HAS_CLOCK = 1'b0
) (
   input  logic                  wr_en,
   input  logic [15:0]           addr,
   input  logic [BANK_ROM_W-1:0] rom_bank,
   input  logic [BANK_RAM_W-1:0] ram_bank,
   input  logic                  ram_en,
   output logic [ROM_PAW-1:0]    rom_addr,
   output logic [RAM_PAW-1:0]    ram_addr,
   output logic                  rd_valid,
   output logic                  ram_we,
   output logic [CLK_REGS-1:0]   clk_sel,
   output logic                  clk_we,
   output logic [7:0]            clk_fill
);
   logic in_rom_fix, in_rom_sw, in_ram;
   logic rom_ok, ram_ok, clk_hit;

   assign in_rom_fix = (addr[15:14] == 2'b00);
   assign in_rom_sw  = (addr[15:14] == 2'b01);
   assign in_ram     = (addr[15:13] == 3'b101);

   assign rom_addr = {(in_rom_sw ? rom_bank : {BANK_ROM_W{1'b0}}), addr[ROM_OFS_W-1:0]};
   assign ram_addr = {ram_bank, addr[RAM_OFS_W-1:0]};

   assign rom_ok = (32'(rom_bank) < 32'(ROM_BANKS));
   assign ram_ok = ram_en && (32'(ram_bank) < 32'(RAM_BANKS));

   generate
      if (HAS_CLOCK) begin : g_clk
         for (genvar k = 0; k < CLK_REGS; k++) begin : g_sel
            assign clk_sel[k] = in_ram && (ram_bank == BANK_RAM_W'(CLK_BASE + k));
         end
         assign clk_hit = |clk_sel;
      end else begin : g_noclk
         assign clk_sel = '0;
         assign clk_hit = 1'b0;
      end
   endgenerate

   assign rd_valid = in_rom_fix | (in_rom_sw & rom_ok) | (in_ram & (clk_hit | ram_ok));
   assign ram_we   = wr_en & in_ram & ~clk_hit & ram_ok;
   assign clk_we   = wr_en & clk_hit;
   assign clk_fill = clk_sel[CLK_REGS-1] ? CLK_LAST_FILL : 8'h00;
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
   import cbc_pkg::*;
#(
   parameter variant_e VARIANT   = VAR_MODE5,
   parameter int       ROM_BANKS = 64,
   parameter int       RAM_BANKS = 4,
   parameter bit       HAS_CLOCK = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [15:0]         addr,
   input  logic [7:0]          wdata,
   output logic [ROM_PAW-1:0]  rom_addr,
   output logic [RAM_PAW-1:0]  ram_addr,
   output logic                rd_valid,
   output logic                ram_we,
   output logic [CLK_REGS-1:0] clk_sel,
   output logic                clk_we,
   output logic [7:0]          clk_fill
);
   localparam int ROM_LIMIT = (VARIANT == VAR_MODE5) ? 128 : 512;

   initial begin
      assert (ROM_BANKS >= 2 && ROM_BANKS <= ROM_LIMIT)
         else $error("ROM_BANKS outside the range the variant can address");
      assert (RAM_BANKS >= 1 && RAM_BANKS <= 256)
         else $error("RAM_BANKS must be 1..256");
   end

   logic [BANK_ROM_W-1:0] rom_bank;
   logic [BANK_RAM_W-1:0] ram_bank;
   logic                  ram_en;
   logic                  bank_mode;

   cbc_bank_regs #(
      .VARIANT(VARIANT), .ROM_BANKS(ROM_BANKS),
      .RAM_BANKS(RAM_BANKS), .HAS_CLOCK(HAS_CLOCK)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rom_bank(rom_bank), .ram_bank(ram_bank), .ram_en(ram_en), .bank_mode(bank_mode)
   );

   cbc_addr_map #(
      .ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS), .HAS_CLOCK(HAS_CLOCK)
   ) u_map (
      .wr_en(wr_en), .addr(addr), .rom_bank(rom_bank), .ram_bank(ram_bank),
      .ram_en(ram_en), .rom_addr(rom_addr), .ram_addr(ram_addr),
      .rd_valid(rd_valid), .ram_we(ram_we), .clk_sel(clk_sel),
      .clk_we(clk_we), .clk_fill(clk_fill)
   );
endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk
   import cbc_pkg::*;
#(
   parameter variant_e VARIANT   = VAR_MODE5,
   parameter int       ROM_BANKS = 64,
   parameter int       RAM_BANKS = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wr_en,
   input logic [15:0]           addr,
   input logic [7:0]            wdata,
   input logic                  rd_valid,
   input logic                  ram_we,
   input logic [CLK_REGS-1:0]   clk_sel,
   input logic [7:0]            clk_fill,
   input logic [BANK_ROM_W-1:0] rom_bank,
   input logic [BANK_RAM_W-1:0] ram_bank,
   input logic                  ram_en,
   input logic                  bank_mode
);
   // R2
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr[15:13] == 3'b000 && wdata == RAM_KEY) |=> ram_en);
   // R2
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr[15:13] == 3'b000 && wdata != RAM_KEY) |=> !ram_en);
   // R3
   bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && !addr[15]) |=> ($stable(rom_bank) && $stable(ram_bank)));
   // R11
   ram_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (rd_valid && ram_en && addr[15:13] == 3'b101));
   // R12
   clk_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clk_sel));
   // R12
   clk_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_fill != 8'h00) |-> (clk_sel[CLK_REGS-1] && !ram_we));

   generate
      if (is_pow2(ROM_BANKS)) begin : g_wrap
         // R7
         rom_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            32'(rom_bank) < 32'(ROM_BANKS));
      end
      if (VARIANT == VAR_MODE5) begin : g_m5
         // R9
         rom_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rom_bank != '0);
         // R6
         mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr[15:13] == 3'b011) |=> (bank_mode == $past(wdata[0])));
      end
   endgenerate
endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk #(
   .VARIANT(VARIANT), .ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .rd_valid(rd_valid), .ram_we(ram_we), .clk_sel(clk_sel), .clk_fill(clk_fill),
   .rom_bank(rom_bank), .ram_bank(ram_bank), .ram_en(ram_en), .bank_mode(bank_mode)
);

// File: tb/cart_bank_ctrl_tb.sv
`timescale 1ns/1ps
module cart_bank_ctrl_tb;
   import cbc_pkg::*;

   // u_dut: narrow layout, 64 ROM banks, 4 RAM banks, no clock
   // u_dut9: wide layout, 48 ROM banks (no wrap), 4 RAM banks, clock fitted
   localparam int N0_ROM = 64, N0_RAM = 4;
   localparam int N1_ROM = 48, N1_RAM = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0;

   always #2.5 clk = ~clk;

   typedef struct packed {
      logic [ROM_PAW-1:0] ra;
      logic [RAM_PAW-1:0] wa;
      logic               v;
      logic               we;
      logic [4:0]         cs;
      logic               cw;
      logic [7:0]         fm;
   } obs_t;

   typedef struct {
      int rom;
      int ram;
      bit en;
      bit mode;
   } mst_t;

   obs_t g0, g1;

   cart_bank_ctrl #(.VARIANT(VAR_MODE5), .ROM_BANKS(N0_ROM), .RAM_BANKS(N0_RAM), .HAS_CLOCK(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rom_addr(g0.ra), .ram_addr(g0.wa), .rd_valid(g0.v), .ram_we(g0.we),
      .clk_sel(g0.cs), .clk_we(g0.cw), .clk_fill(g0.fm));

   cart_bank_ctrl #(.VARIANT(VAR_WIDE9), .ROM_BANKS(N1_ROM), .RAM_BANKS(N1_RAM), .HAS_CLOCK(1'b1)) u_dut9 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rom_addr(g1.ra), .ram_addr(g1.wa), .rd_valid(g1.v), .ram_we(g1.we),
      .clk_sel(g1.cs), .clk_we(g1.cw), .clk_fill(g1.fm));

   int checks = 0;
   int errors = 0;
   mst_t m0, m1;

   function automatic bit pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

   function automatic mst_t mstep(mst_t s, int wide, int nrom, int nram, bit clkp,
                                  logic [15:0] a, logic [7:0] d);
      mst_t n = s;
      int low;
      if (a[15]) return s;
      case (a[14:12])
         3'd0, 3'd1: n.en = (d == 8'h0A);
         3'd2, 3'd3: begin
            if (wide == 0) begin
               low = d & 31;
               if (low == 0) low = 1;
               n.rom = (s.rom & ~31) | low;
            end else if (a[14:12] == 3'd2) n.rom = (s.rom & 256) | d;
            else n.rom = (s.rom & 255) | (d[0] ? 256 : 0);
         end
         3'd4, 3'd5: begin
            if (wide != 0) n.ram = d;
            else if (s.mode) n.ram = d & 3;
            else n.rom = (s.rom & ~96) | ((d & 3) << 5);
         end
         default: begin
            if (wide == 0) begin
               if (d[0] && !s.mode) begin
                  n.ram = (s.rom >> 5) & 3;
                  n.rom = s.rom & ~96;
               end else if (!d[0] && s.mode) begin
                  n.rom = (s.rom & ~96) | ((s.ram & 3) << 5);
                  n.ram = 0;
               end
               n.mode = d[0];
            end
         end
      endcase
      if (pow2(nrom)) n.rom = n.rom % nrom;
      if (pow2(nram) && !(clkp && n.ram >= 8 && n.ram <= 12)) n.ram = n.ram % nram;
      if (wide == 0 && n.rom == 0) n.rom = 1;
      return n;
   endfunction

   function automatic obs_t expect_of(mst_t s, int nrom, int nram, bit clkp,
                                      logic [15:0] a, bit we);
      obs_t e;
      bit win = (a[15:13] == 3'b101);
      bit hit = clkp && win && s.ram >= 8 && s.ram <= 12;
      bit rok = s.en && s.ram < nram;
      e.ra = ROM_PAW'(((a[15:14] == 2'b01) ? s.rom : 0) * 16384 + a[13:0]);
      e.wa = RAM_PAW'(s.ram * 8192 + a[12:0]);
      if (!a[15]) e.v = !a[14] ? 1'b1 : (s.rom < nrom);
      else        e.v = win && (hit || rok);
      e.we = we && win && !hit && rok;
      e.cs = hit ? 5'(1 << (s.ram - 8)) : 5'd0;
      e.cw = we && hit;
      e.fm = (hit && s.ram == 12) ? 8'h3E : 8'h00;
      return e;
   endfunction

   task automatic cmp(string tag, string dn, string f, longint got, longint exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s %s addr=%h actual=%h expected=%h", tag, dn, f, addr, got, exp);
      end
   endtask

   task automatic cmp_obs(string tag, string dn, obs_t g, obs_t e);
      cmp(tag, dn, "rom_addr", g.ra, e.ra);
      cmp(tag, dn, "ram_addr", g.wa, e.wa);
      cmp(tag, dn, "rd_valid", g.v, e.v);
      cmp(tag, dn, "ram_we", g.we, e.we);
      cmp(tag, dn, "clk_sel", g.cs, e.cs);
      cmp(tag, dn, "clk_we", g.cw, e.cw);
      cmp(tag, dn, "clk_fill", g.fm, e.fm);
   endtask

   // drive on the falling edge, check the mapping, let the rising edge commit
   task automatic io(input logic [15:0] a, input logic [7:0] d, input bit we, input string tag);
      string t;
      @(negedge clk);
      addr = a; wdata = d; wr_en = we;
      #1;
      t = tag;
      if (t == "") begin
         if (a[15:14] == 2'b00)      t = "R13";
         else if (a[15:14] == 2'b01) t = a[15] ? "R13" : "R10";
         else if (a[15:13] == 3'b101) t = "R11";
         else                         t = "R13";
      end
      cmp_obs(t, "u_dut", g0, expect_of(m0, N0_ROM, N0_RAM, 1'b0, a, we));
      cmp_obs(t, "u_dut9", g1, expect_of(m1, N1_ROM, N1_RAM, 1'b1, a, we));
      @(posedge clk);
      if (we) begin
         m0 = mstep(m0, 0, N0_ROM, N0_RAM, 1'b0, a, d);
         m1 = mstep(m1, 1, N1_ROM, N1_RAM, 1'b1, a, d);
      end
   endtask

   initial begin
      #(5.0 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] ra;
      logic [7:0]  rd;
      int unsigned seed;
      m0 = '{rom: 1, ram: 0, en: 1'b0, mode: 1'b0};
      m1 = '{rom: 1, ram: 0, en: 1'b0, mode: 1'b0};
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state seen through the windows
      io(16'h4000, 8'h00, 1'b0, "R1");
      io(16'hA010, 8'h00, 1'b0, "R1");
      // R2: enable key and any other value
      io(16'h0123, 8'h0A, 1'b1, "R2");
      io(16'hA010, 8'h55, 1'b1, "R2");
      io(16'h1FFF, 8'h0B, 1'b1, "R2");
      io(16'hA010, 8'h55, 1'b1, "R2");
      io(16'h0000, 8'h0A, 1'b1, "R2");
      // R3: zero written, then masked value
      io(16'h2000, 8'h00, 1'b1, "R3");
      io(16'h4123, 8'h00, 1'b0, "R3");
      io(16'h2ABC, 8'hE5, 1'b1, "R3");
      io(16'h7FFF, 8'h00, 1'b0, "R3");
      // R4: upper bit in wide layout, alias in narrow
      io(16'h3000, 8'h01, 1'b1, "R4");
      io(16'h5555, 8'h00, 1'b0, "R4");
      io(16'h3FFF, 8'h00, 1'b1, "R4");
      io(16'h4001, 8'h00, 1'b0, "R4");
      // R5 / R7: shared field into ROM bits 6:5 with wrap
      io(16'h2000, 8'h02, 1'b1, "R5");
      io(16'h4000, 8'h03, 1'b1, "R5");
      io(16'h6000, 8'h00, 1'b0, "R7");
      // R6: mode transitions move the shared field
      io(16'h6000, 8'h01, 1'b1, "R6");
      io(16'hA000, 8'h00, 1'b0, "R6");
      io(16'h5000, 8'h02, 1'b1, "R5");
      io(16'hB000, 8'h77, 1'b1, "R6");
      io(16'h7000, 8'h00, 1'b1, "R6");
      io(16'h4444, 8'h00, 1'b0, "R6");
      // R9: narrow bank never zero
      io(16'h2000, 8'h20, 1'b1, "R9");
      io(16'h4000, 8'h00, 1'b0, "R9");
      // R8 / R12: RAM bank wrap and clock redirection
      io(16'h4000, 8'h05, 1'b1, "R8");
      io(16'hA000, 8'h00, 1'b0, "R8");
      io(16'h4000, 8'h0C, 1'b1, "R12");
      io(16'h1000, 8'h00, 1'b1, "R12");
      io(16'hA000, 8'h00, 1'b0, "R12");
      io(16'hBFFF, 8'h81, 1'b1, "R12");
      io(16'h4000, 8'h08, 1'b1, "R12");
      io(16'hA100, 8'h00, 1'b0, "R12");
      io(16'h4000, 8'h0D, 1'b1, "R8");
      io(16'hA100, 8'h00, 1'b0, "R8");
      // R11: enabled RAM write strobe, R13: unmapped regions
      io(16'h0000, 8'h0A, 1'b1, "R11");
      io(16'hA7FF, 8'h12, 1'b1, "R11");
      io(16'h8000, 8'h00, 1'b0, "R13");
      io(16'hC000, 8'h00, 1'b1, "R13");
      io(16'h1234, 8'h00, 1'b0, "R13");

      // constrained random traffic
      seed = $urandom(32'h5EED_C0DE);
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = int'($urandom_range(0, 9));
         case (r)
            0, 1, 2, 3: ra = 16'($urandom_range(16'h0000, 16'h7FFF));
            4, 5:       ra = 16'($urandom_range(16'h4000, 16'h7FFF));
            6, 7:       ra = 16'($urandom_range(16'hA000, 16'hBFFF));
            default:    ra = 16'($urandom);
         endcase
         r = int'($urandom_range(0, 7));
         if (r < 2)       rd = 8'h0A;
         else if (r == 2) rd = 8'(8 + $urandom_range(0, 4));
         else             rd = 8'($urandom);
         io(ra, rd, 1'($urandom_range(0, 1)), "");
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule